// File: doc/BRIEF.md
# Single-Wire Device Reset Responder and Slot Timer

This block is the device end of an open-drain single-wire line. It watches the line through a synchronizer and measures how long the line stays low. When a low period long enough to count as a bus reset ends, the block waits a short gap. It then pulls the line low for a fixed interval to announce that it is present.

Outside of reset handling, each falling edge that the master makes on the line starts a slot. An internal delay measured from that edge sets the timing of the slot. In a write slot, the block samples the line when the delay expires and reports the bit with a one-cycle strobe. In a read slot, the block returns the value on `tx_bit_i`. A 0 is returned by pulling the line low until the delay expires. A 1 is returned by leaving the line alone.

Command decoding and data storage belong to the logic around this block. That logic selects read or write slots with `read_mode_i` and supplies the bit to return.

Top module: `owire_responder`

## Requirements
- R1: The line input passes through two synchronizing flops and an edge detector. A master falling edge is acted on two clock edges after the first flop captures it.
- R2: A synchronized low period of at least RESET_MIN_US*CLK_PER_US cycles is a reset when the line rises again. A low period one cycle shorter is not a reset.
- R3: After the rising edge that ends a reset, `pull_low_o` asserts exactly PRES_WAIT_US*CLK_PER_US cycles after the block enters its wait state.
- R4: The presence pulse keeps `pull_low_o` high for exactly PRES_LEN_US*CLK_PER_US cycles.
- R5: In a write slot (`read_mode_i`=0), `rx_bit_o` takes the synchronized line value SLOT_US*CLK_PER_US cycles after the slot starts, and `rx_valid_o` is 1 in the same cycle.
- R6: `rx_valid_o` is never high for two consecutive cycles.
- R7: In a read slot with `tx_bit_i`=0, `pull_low_o` is high from slot start until the slot delay expires. The line is therefore held low for SLOT_US*CLK_PER_US+2 cycles after the master's falling edge.
- R8: In a read slot with `tx_bit_i`=1, the block never drives the line. Read slots never raise `rx_valid_o`.
- R9: A new falling edge during an undriven slot restarts the delay. Only the last edge produces a sample.
- R10: The falling edge that the block's own presence pulse creates is ignored, so the presence pulse runs its full length.
- R11: While `rst_n` is low, `pull_low_o` and `rx_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw level of the shared line |
| tx_bit_i | input | 1 | Bit to return in a read slot, taken at the slot's falling edge |
| read_mode_i | input | 1 | 1 selects read slots, 0 selects write slots; taken at the falling edge |
| pull_low_o | output | 1 | Enable for the open-drain pull-down |
| rx_bit_o | output | 1 | Bit captured in the last write slot |
| rx_valid_o | output | 1 | One-cycle strobe marking a new `rx_bit_o` |

## Verification
The bench builds the block with CLK_PER_US=2 and keeps the default microsecond values. The reset threshold is therefore 960 cycles, the presence gap 60, the pulse 240 and the slot delay 60. At this scale a reset that exactly meets the threshold and one that misses it by a single cycle both fit into a short run. Every sample point and presence edge can be checked to the exact cycle, so a delay that is off by one cycle shows up as a failure.

// File: rtl/owr_pkg.sv
package owr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PWAIT  = 2'd1,
        ST_PDRIVE = 2'd2,
        ST_SLOT   = 2'd3
    } owr_state_e;

    function automatic int unsigned owr_max3(input int unsigned a, input int unsigned b,
                                             input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/owr_line_sync.sv
module owr_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic fall_o,
    output logic rise_o
);
    typedef struct packed {
        logic meta;
        logic stable;
        logic last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = line_i;
        sync_d.stable = sync_q.meta;
        sync_d.last   = sync_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{meta: 1'b1, stable: 1'b1, last: 1'b1};
        else        sync_q <= sync_d;
    end

    assign line_o = sync_q.stable;
    assign fall_o = sync_q.last & ~sync_q.stable;
    assign rise_o = ~sync_q.last & sync_q.stable;

    // R1
    fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/owr_low_timer.sv
module owr_low_timer #(
    parameter int unsigned LIMIT_CYC = 960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic long_low_o
);
    localparam int unsigned W = $clog2(LIMIT_CYC + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT_CYC - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         long_low;
    } lt_t;

    lt_t lt_d, lt_q;

    always_comb begin
        lt_d = lt_q;
        if (line_i) begin
            lt_d.cnt      = '0;
            lt_d.long_low = 1'b0;
        end else begin
            if (lt_q.cnt != LAST) lt_d.cnt = lt_q.cnt + 1'b1;
            if (lt_q.cnt == LAST) lt_d.long_low = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lt_q <= '0;
        else        lt_q <= lt_d;
    end

    assign long_low_o = lt_q.long_low;

    // R2
    long_low_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(long_low_o) |-> $past(!line_i));

endmodule

// File: rtl/owr_span_ctr.sv
module owr_span_ctr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } sc_t;

    sc_t sc_d, sc_q;

    always_comb begin
        sc_d = sc_q;
        if (clr_i)              sc_d.cnt = '0;
        else if (~&sc_q.cnt)    sc_d.cnt = sc_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign cnt_o = sc_q.cnt;

    // R9
    ctr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&cnt_o) |=> ((&cnt_o) || cnt_o == '0));

endmodule

// File: rtl/owire_responder.sv
module owire_responder
    import owr_pkg::*;
#(
    parameter int unsigned CLK_PER_US   = 50,
    parameter int unsigned RESET_MIN_US = 480,
    parameter int unsigned PRES_WAIT_US = 30,
    parameter int unsigned PRES_LEN_US  = 120,
    parameter int unsigned SLOT_US      = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic tx_bit_i,
    input  logic read_mode_i,
    output logic pull_low_o,
    output logic rx_bit_o,
    output logic rx_valid_o
);
    localparam int unsigned RESET_CYC = RESET_MIN_US * CLK_PER_US;
    localparam int unsigned WAIT_CYC  = PRES_WAIT_US * CLK_PER_US;
    localparam int unsigned PRES_CYC  = PRES_LEN_US * CLK_PER_US;
    localparam int unsigned SLOT_CYC  = SLOT_US * CLK_PER_US;
    localparam int unsigned MAX_CYC   = owr_max3(WAIT_CYC, PRES_CYC, SLOT_CYC);
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] PRES_LAST = CNT_W'(PRES_CYC - 1);
    localparam logic [CNT_W-1:0] SLOT_LAST = CNT_W'(SLOT_CYC - 1);

    typedef struct packed {
        owr_state_e state;
        logic       rdmode;
        logic       drive;
        logic       rx_bit;
        logic       rx_valid;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             line_s;
    logic             fall_s;
    logic             rise_s;
    logic             long_low;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt;

    owr_line_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_i),
        .line_o (line_s),
        .fall_o (fall_s),
        .rise_o (rise_s)
    );

    owr_low_timer #(.LIMIT_CYC(RESET_CYC)) u_low (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_s),
        .long_low_o (long_low)
    );

    owr_span_ctr #(.W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .cnt_o (cnt)
    );

    assign pull_low_o = (ctl_q.state == ST_PDRIVE) ||
                        ((ctl_q.state == ST_SLOT) && ctl_q.drive);

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rx_valid = 1'b0;
        cnt_clr        = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: ;
            ST_PWAIT: begin
                if (cnt == WAIT_LAST) begin
                    ctl_d.state = ST_PDRIVE;
                    cnt_clr     = 1'b1;
                end
            end
            ST_PDRIVE: begin
                if (cnt == PRES_LAST) ctl_d.state = ST_IDLE;
            end
            ST_SLOT: begin
                if (cnt == SLOT_LAST) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.drive = 1'b0;
                    if (!ctl_q.rdmode) begin
                        ctl_d.rx_bit   = line_s;
                        ctl_d.rx_valid = 1'b1;
                    end
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase

        // a master edge starts or restarts a slot unless the block is driving
        if (fall_s && !pull_low_o &&
            (ctl_q.state == ST_IDLE || ctl_q.state == ST_SLOT)) begin
            ctl_d.state  = ST_SLOT;
            ctl_d.rdmode = read_mode_i;
            ctl_d.drive  = read_mode_i & ~tx_bit_i;
            cnt_clr      = 1'b1;
        end

        // end of a reset has priority over everything else
        if (rise_s && long_low) begin
            ctl_d.state = ST_PWAIT;
            ctl_d.drive = 1'b0;
            cnt_clr     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{state: ST_IDLE, rdmode: 1'b0, drive: 1'b0,
                               rx_bit: 1'b0, rx_valid: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign rx_bit_o   = ctl_q.rx_bit;
    assign rx_valid_o = ctl_q.rx_valid;

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R8
    strobe_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> ($past(ctl_q.state) == ST_SLOT && !$past(ctl_q.rdmode)));

    // R3
    presence_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_PDRIVE && $past(ctl_q.state) != ST_PDRIVE)
            |-> $past(ctl_q.state) == ST_PWAIT);

    // R10
    presence_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_PDRIVE && cnt != PRES_LAST && !(rise_s && long_low))
            |=> ctl_q.state == ST_PDRIVE);

endmodule

// File: tb/owire_responder_bench.sv
module owire_responder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 2;
    localparam int RESET_CYC  = 480 * CPU;
    localparam int WAIT_CYC   = 30 * CPU;
    localparam int PRES_CYC   = 120 * CPU;
    localparam int SLOT_CYC   = 30 * CPU;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_low = 1'b0;
    logic tx_bit = 1'b1;
    logic read_mode = 1'b0;
    logic line;
    logic pull_low, rx_bit, rx_valid;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    int n_strobes = 0;
    bit done = 1'b0;
    logic prev_v = 1'b0;

    typedef struct { logic b; int at; } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign line = ~(master_low | pull_low);

    owire_responder #(.CLK_PER_US(CPU)) u_owire_responder (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_i      (line),
        .tx_bit_i    (tx_bit),
        .read_mode_i (read_mode),
        .pull_low_o  (pull_low),
        .rx_bit_o    (rx_bit),
        .rx_valid_o  (rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                n_strobes++;
                chk(!prev_v, "R6 strobe width", 2, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5/R8 unexpected strobe", int'(rx_bit), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rx_bit == e.b, "R5 sampled bit", int'(rx_bit), int'(e.b));
                    chk(cyc == e.at, "R5 sample cycle", cyc, e.at);
                end
            end
            prev_v = rx_valid;
        end
    end

    task automatic write_slot(input logic b);
        int c0;
        read_mode = 1'b0;
        @(negedge clk);
        master_low = 1'b1;
        c0 = cyc;
        exp_q.push_back('{b: b, at: c0 + SLOT_CYC + 3});
        repeat (b ? 6 : 120) @(negedge clk);
        master_low = 1'b0;
        repeat (b ? 150 : 40) @(negedge clk);
    endtask

    task automatic read_slot(input logic tb);
        int n;
        int s0;
        read_mode = 1'b1;
        tx_bit = tb;
        s0 = n_strobes;
        @(negedge clk);
        master_low = 1'b1;
        n = 0;
        for (int i = 1; i < 300; i++) begin
            @(negedge clk);
            if (i == 4) master_low = 1'b0;
            #1;
            if (!line) n++;
            else break;
        end
        if (tb) chk(n == 3, "R8 read-1 line low length", n, 3);
        else    chk(n == SLOT_CYC + 2, "R7 read-0 line low length", n, SLOT_CYC + 2);
        repeat (100) @(negedge clk);
        chk(n_strobes == s0, "R8 no strobe in read slot", n_strobes - s0, 0);
        read_mode = 1'b0;
    endtask

    task automatic reset_pulse(input int low_cyc, input bit expect_pres);
        int r0;
        int t_on;
        int t_off;
        read_mode = 1'b0;
        @(negedge clk);
        master_low = 1'b1;
        exp_q.push_back('{b: 1'b0, at: cyc + SLOT_CYC + 3});
        repeat (low_cyc) @(negedge clk);
        master_low = 1'b0;
        r0 = cyc;
        t_on = -1;
        t_off = -1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (pull_low && t_on < 0) t_on = cyc;
            if (!pull_low && t_on >= 0) begin
                t_off = cyc;
                break;
            end
        end
        if (expect_pres) begin
            chk(t_on == r0 + WAIT_CYC + 3, "R2/R3 presence start", t_on, r0 + WAIT_CYC + 3);
            chk(t_off - t_on == PRES_CYC, "R4/R10 presence length", t_off - t_on, PRES_CYC);
        end else begin
            chk(t_on < 0, "R2 short low gives no presence", t_on, -1);
        end
        repeat (50) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11
        chk(pull_low == 1'b0, "R11 reset pull_low", int'(pull_low), 0);
        chk(rx_valid == 1'b0, "R11 reset rx_valid", int'(rx_valid), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R2 R3 R4 R10: exact threshold, longer, one short
        reset_pulse(RESET_CYC, 1'b1);
        reset_pulse(RESET_CYC + 200, 1'b1);
        reset_pulse(RESET_CYC - 1, 1'b0);

        // R1 R5: write patterns
        for (int i = 0; i < 8; i++) write_slot(logic'((8'b1011_0010 >> i) & 1));

        // R7 R8: read slots
        read_slot(1'b0);
        read_slot(1'b1);
        read_slot(1'b0);

        // R9: restart of the delay by a second falling edge
        begin
            int c1;
            read_mode = 1'b0;
            @(negedge clk);
            master_low = 1'b1;
            repeat (10) @(negedge clk);
            master_low = 1'b0;
            repeat (10) @(negedge clk);
            master_low = 1'b1;
            c1 = cyc;
            exp_q.push_back('{b: 1'b0, at: c1 + SLOT_CYC + 3});
            repeat (120) @(negedge clk);
            master_low = 1'b0;
            repeat (100) @(negedge clk);
        end

        write_slot(1'b1);
        reset_pulse(RESET_CYC, 1'b1);

        repeat (50) @(negedge clk);
        chk(exp_q.size() == 0, "R5/R9 all expected strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule